// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block produces the request side of a DMA handshake for a serial interface that holds a receive FIFO and a transmit FIFO of equal depth (8 entries by default). For each direction it drives two requests: a single-transfer request and a burst-transfer request. It takes one request-clear strobe per direction back from the DMA controller. Its inputs are the current fill count of each FIFO, a burst watermark for each direction, a DMA enable for each direction and an enable for the whole interface. Everything runs on one clock.

The receive side asks for data to be drained. It asks for a single character as soon as anything is stored, and for a burst once the fill count reaches the burst length. The transmit side asks for data to be supplied. It asks for a single character while any slot is free, and for a burst once the number of free slots reaches the burst length. The two triggers are mirror images of each other. Both kinds of request may be active together. A request is sticky: once raised it stays high until the DMA controller pulses the matching clear, which it does on the last beat of a burst. A controller can therefore move the bulk of a stream in bursts and finish the tail with single transfers.

Top module: `dma_fifo_req`

## Requirements
- R1: The receive single request rises one clock after a cycle in which the receive fill count is 1 or more, with the direction active and its clear low.
- R2: The receive burst request rises one clock after a cycle in which the receive fill count is at least L. The 3-bit watermark field value w encodes a burst length of L = w + 1 (w = 0..7 gives L = 1..8).
- R3: The transmit single request rises one clock after a cycle in which the transmit fill count is below the depth (8).
- R4: The transmit burst request rises one clock after a cycle in which the transmit fill count is at most 8 − L, with L = w + 1 as in R2.
- R5: Single and burst requests may be high together. When the burst condition does not hold but the single condition does, only the single request is raised.
- R6: Once high, a request stays high, whatever the fill count does, for as long as its direction stays active and its clear stays low.
- R7: A clear input held high in a cycle drives both requests of that direction low at the next clock, and keeps them low while it stays high. One clock after the clear falls, a request re-asserts if its condition holds.
- R8: A direction is active only while the interface enable and that direction's DMA enable are both high. Its request outputs are low in every cycle in which it is inactive. Held requests are discarded, so after re-enabling they re-arm only through R1 to R4.
- R9: The clear and enable of one direction have no effect on the requests of the other direction.
- R10: With a watermark field of 3, a 19-character receive stream served by a controller that takes bursts whenever offered completes as four bursts of four characters followed by three single transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_level | input | 4 | Receive FIFO fill count (0..8) |
| tx_level | input | 4 | Transmit FIFO fill count (0..8) |
| rx_wmark | input | 3 | Receive watermark field (burst length − 1) |
| tx_wmark | input | 3 | Transmit watermark field (burst length − 1) |
| rx_clr | input | 1 | Receive request clear from the DMA controller |
| tx_clr | input | 1 | Transmit request clear from the DMA controller |
| rx_sreq | output | 1 | Receive single-transfer request |
| rx_breq | output | 1 | Receive burst-transfer request |
| tx_sreq | output | 1 | Transmit single-transfer request |
| tx_breq | output | 1 | Transmit burst-transfer request |

## Verification
The assertions check on every cycle that a held request survives while its direction is active and uncleared, that a clear empties both requests at the next edge, that a request only rises after its trigger condition held, and that an inactive direction shows no request while the other direction is unaffected. The exact trigger points for every watermark value in both directions, the mirrored transmit thresholds, and the way a stream splits into bursts and a tail of singles can only be shown by the bench's scenarios, which compare the outputs against thresholds computed from the encoding.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

   // Direction selector used to pick the trigger variant.
   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } dir_e;

   // A single/burst request pair.
   typedef struct packed {
      logic single;
      logic burst;
   } req_pair_t;

   // Bits needed to hold a fill count from 0 to depth inclusive.
   function automatic int unsigned level_width(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   // Bits needed for a watermark field encoding burst lengths 1..depth.
   function automatic int unsigned wmark_width(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/dma_req_trigger.sv
module dma_req_trigger
   import dma_req_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter dir_e        DIR   = DIR_RX,
   localparam int unsigned CNT_W = level_width(DEPTH),
   localparam int unsigned WM_W  = wmark_width(DEPTH)
) (
   input  logic [CNT_W-1:0] level,
   input  logic [WM_W-1:0]  wmark,
   output req_pair_t        cond
);

   localparam logic [CNT_W:0] FULL_X = (CNT_W+1)'(DEPTH);

   // Burst length in entries: field value plus one.
   logic [CNT_W:0] blen_x;
   logic [CNT_W:0] level_x;
   logic           single_c;
   logic           burst_c;

   assign blen_x  = (CNT_W+1)'(wmark) + (CNT_W+1)'(1);
   assign level_x = {1'b0, level};

   generate
      if (DIR == DIR_RX) begin : g_rx
         // Drain side: count filled entries.
         assign single_c = (level_x != '0);
         assign burst_c  = (level_x >= blen_x);
      end else begin : g_tx
         // Fill side: count free slots, i.e. DEPTH - level >= burst length.
         assign single_c = (level_x < FULL_X);
         assign burst_c  = ((level_x + blen_x) <= FULL_X);
      end
   endgenerate

   assign cond = '{single: single_c, burst: burst_c};

endmodule

// File: rtl/dma_req_hold.sv
module dma_req_hold
   import dma_req_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      active,
   input  logic      clr,
   input  req_pair_t cond,
   output req_pair_t req
);

   logic s_q, b_q;
   logic s_nxt, b_nxt;

   always_comb begin
      s_nxt = s_q;
      b_nxt = b_q;
      if (!active || clr) begin
         s_nxt = 1'b0;
         b_nxt = 1'b0;
      end else begin
         s_nxt = s_q | cond.single;
         b_nxt = b_q | cond.burst;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q <= 1'b0;
         b_q <= 1'b0;
      end else begin
         s_q <= s_nxt;
         b_q <= b_nxt;
      end
   end

   assign req = '{single: s_q & active, burst: b_q & active};

   // R6
   single_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && active && !clr) |=> s_q);

   // R6
   burst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_q && active && !clr) |=> b_q);

   // R7
   clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!s_q && !b_q));

   // R1 R3
   single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_q) |-> $past(cond.single));

   // R2 R4
   burst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(b_q) |-> $past(cond.burst));

endmodule

// File: rtl/dma_fifo_req.sv
module dma_fifo_req
   import dma_req_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned CNT_W = level_width(DEPTH),
   localparam int unsigned WM_W  = wmark_width(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             if_en,
   input  logic             rx_dma_en,
   input  logic             tx_dma_en,
   input  logic [CNT_W-1:0] rx_level,
   input  logic [CNT_W-1:0] tx_level,
   input  logic [WM_W-1:0]  rx_wmark,
   input  logic [WM_W-1:0]  tx_wmark,
   input  logic             rx_clr,
   input  logic             tx_clr,
   output logic             rx_sreq,
   output logic             rx_breq,
   output logic             tx_sreq,
   output logic             tx_breq
);

   // Elaboration checks: the watermark field must map exactly onto 1..DEPTH.
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dma_fifo_req: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("dma_fifo_req: DEPTH must be a power of two");
      end
   endgenerate

   logic      rx_active, tx_active;
   req_pair_t rx_cond, tx_cond;
   req_pair_t rx_req, tx_req;

   assign rx_active = if_en & rx_dma_en;
   assign tx_active = if_en & tx_dma_en;

   dma_req_trigger #(.DEPTH(DEPTH), .DIR(DIR_RX)) i_rx_trig (
      .level (rx_level),
      .wmark (rx_wmark),
      .cond  (rx_cond)
   );

   dma_req_trigger #(.DEPTH(DEPTH), .DIR(DIR_TX)) i_tx_trig (
      .level (tx_level),
      .wmark (tx_wmark),
      .cond  (tx_cond)
   );

   dma_req_hold i_rx_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (rx_active),
      .clr    (rx_clr),
      .cond   (rx_cond),
      .req    (rx_req)
   );

   dma_req_hold i_tx_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (tx_active),
      .clr    (tx_clr),
      .cond   (tx_cond),
      .req    (tx_req)
   );

   assign rx_sreq = rx_req.single;
   assign rx_breq = rx_req.burst;
   assign tx_sreq = tx_req.single;
   assign tx_breq = tx_req.burst;

   // R8
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(if_en && rx_dma_en) |-> (!rx_sreq && !rx_breq));

   // R8
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(if_en && tx_dma_en) |-> (!tx_sreq && !tx_breq));

   // R9
   tx_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sreq && !tx_clr && if_en && tx_dma_en) |=> (tx_sreq || !(if_en && tx_dma_en)));

   // R9
   rx_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_breq && !rx_clr && if_en && rx_dma_en) |=> (rx_breq || !(if_en && rx_dma_en)));

endmodule

// File: tb/test_dma_fifo_req.sv
module test_dma_fifo_req;

   localparam int DEPTH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       if_en = 1'b0;
   logic       rx_dma_en = 1'b0;
   logic       tx_dma_en = 1'b0;
   logic [3:0] rx_level = '0;
   logic [3:0] tx_level = '0;
   logic [2:0] rx_wmark = '0;
   logic [2:0] tx_wmark = '0;
   logic       rx_clr = 1'b0;
   logic       tx_clr = 1'b0;
   logic       rx_sreq, rx_breq, tx_sreq, tx_breq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   dma_fifo_req #(.DEPTH(DEPTH)) i_dma_fifo_req (
      .clk(clk), .rst_n(rst_n), .if_en(if_en),
      .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
      .rx_level(rx_level), .tx_level(tx_level),
      .rx_wmark(rx_wmark), .tx_wmark(tx_wmark),
      .rx_clr(rx_clr), .tx_clr(tx_clr),
      .rx_sreq(rx_sreq), .rx_breq(rx_breq),
      .tx_sreq(tx_sreq), .tx_breq(tx_breq)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_both();
      rx_clr = 1'b1; tx_clr = 1'b1;
      tick();
      rx_clr = 1'b0; tx_clr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R8", "rx_sreq at reset", rx_sreq, 0);
      chk("R8", "rx_breq at reset", rx_breq, 0);
      chk("R8", "tx_sreq at reset", tx_sreq, 0);
      chk("R8", "tx_breq at reset", tx_breq, 0);
   endtask

   // R1 R3: single thresholds
   task automatic t_single();
      rx_wmark = 3'd7; tx_wmark = 3'd7;
      rx_level = 4'd0; tx_level = 4'd8;
      clear_both();
      tick();
      chk("R1", "rx_sreq at level 0", rx_sreq, 0);
      chk("R3", "tx_sreq at level 8", tx_sreq, 0);
      rx_level = 4'd1; tx_level = 4'd7;
      tick();
      chk("R1", "rx_sreq at level 1", rx_sreq, 1);
      chk("R3", "tx_sreq at level 7", tx_sreq, 1);
   endtask

   // R2 R4 R5: sweep every watermark value
   task automatic t_sweep();
      for (int w = 0; w < 8; w++) begin
         int l = w + 1;
         rx_wmark = 3'(w); tx_wmark = 3'(w);
         rx_level = 4'(l - 1); tx_level = 4'(DEPTH - l + 1);
         clear_both();
         tick();
         chk("R2", $sformatf("rx_breq w=%0d below", w), rx_breq, 0);
         chk("R5", $sformatf("rx_sreq w=%0d below", w), rx_sreq, (l - 1 >= 1) ? 1 : 0);
         chk("R4", $sformatf("tx_breq w=%0d below", w), tx_breq, 0);
         chk("R5", $sformatf("tx_sreq w=%0d below", w), tx_sreq, (DEPTH - l + 1 < DEPTH) ? 1 : 0);
         rx_level = 4'(l); tx_level = 4'(DEPTH - l);
         tick();
         chk("R2", $sformatf("rx_breq w=%0d at", w), rx_breq, 1);
         chk("R5", $sformatf("rx_sreq w=%0d at", w), rx_sreq, 1);
         chk("R4", $sformatf("tx_breq w=%0d at", w), tx_breq, 1);
         chk("R5", $sformatf("tx_sreq w=%0d at", w), tx_sreq, 1);
      end
   endtask

   // R6 R7 R9: sticky hold, clear, re-arm, isolation
   task automatic t_sticky();
      rx_wmark = 3'd3; tx_wmark = 3'd3;
      rx_level = 4'd5; tx_level = 4'd2;
      clear_both();
      tick();
      chk("R6", "rx_breq raised", rx_breq, 1);
      rx_level = 4'd0;
      tick(); tick();
      chk("R6", "rx_breq held after drain", rx_breq, 1);
      chk("R6", "rx_sreq held after drain", rx_sreq, 1);
      rx_level = 4'd5;
      rx_clr = 1'b1;
      tick();
      chk("R7", "rx_breq after clear", rx_breq, 0);
      chk("R7", "rx_sreq after clear", rx_sreq, 0);
      chk("R9", "tx_breq kept on rx clear", tx_breq, 1);
      chk("R9", "tx_sreq kept on rx clear", tx_sreq, 1);
      tick();
      chk("R7", "rx_breq while clear held", rx_breq, 0);
      rx_clr = 1'b0;
      tick();
      chk("R7", "rx_breq re-armed", rx_breq, 1);
      chk("R7", "rx_sreq re-armed", rx_sreq, 1);
   endtask

   // R8 R9: enable gating
   task automatic t_enable();
      rx_dma_en = 1'b0;
      #1;
      chk("R8", "rx_sreq gated same cycle", rx_sreq, 0);
      chk("R8", "rx_breq gated same cycle", rx_breq, 0);
      chk("R9", "tx_sreq unaffected by rx enable", tx_sreq, 1);
      rx_level = 4'd0;
      tick();
      rx_dma_en = 1'b1;
      #1;
      chk("R8", "rx_sreq not restored on re-enable", rx_sreq, 0);
      tick();
      chk("R8", "rx_sreq stays low with empty fifo", rx_sreq, 0);
      if_en = 1'b0;
      #1;
      chk("R8", "tx_sreq gated by interface", tx_sreq, 0);
      chk("R8", "tx_breq gated by interface", tx_breq, 0);
      tick();
      if_en = 1'b1;
      tx_level = 4'd8;
      #1;
      chk("R8", "tx_sreq discarded", tx_sreq, 0);
      tick();
      chk("R8", "tx_sreq stays low with full fifo", tx_sreq, 0);
   endtask

   // R10: 19 characters, burst length 4
   task automatic t_stream();
      int fill = 0, pushed = 0, got = 0, beats = 0;
      int bursts = 0, singles = 0, bad_burst = 0;
      rx_wmark = 3'd3;
      rx_level = 4'd0;
      rx_clr = 1'b1;
      tick();
      rx_clr = 1'b0;
      for (int c = 0; c < 2000 && got < 19; c++) begin
         tick();
         rx_clr = 1'b0;
         if (beats == 0) begin
            if (rx_breq) begin
               if (fill < 4) bad_burst++;
               beats = 4; bursts++;
            end else if (rx_sreq && pushed == 19) begin
               beats = 1; singles++;
            end
         end
         if (fill < DEPTH && pushed < 19) begin
            fill++; pushed++;
         end
         if (beats > 0) begin
            fill--; got++; beats--;
            if (beats == 0) rx_clr = 1'b1;
         end
         rx_level = 4'(fill);
      end
      tick();
      rx_clr = 1'b0;
      chk("R10", "characters received", got, 19);
      chk("R10", "bursts", bursts, 4);
      chk("R10", "singles", singles, 3);
      chk("R2", "burst offered below watermark", bad_burst, 0);
   endtask

   initial begin
      repeat (2) tick();
      t_reset();
      rst_n = 1'b1;
      if_en = 1'b1; rx_dma_en = 1'b1; tx_dma_en = 1'b1;
      tick();
      t_single();
      t_sweep();
      t_sticky();
      t_enable();
      t_stream();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule